// File: doc/BRIEF.md
# Configurable Address Window Decoder

This block holds a bank of address decoding windows that route processor accesses in a 36-bit physical space to devices. Software programs each window through a small register port: a control word, a base word and, for the low-numbered windows only, a remap pair. The control word holds an enable bit, a sync-barrier flag, a 4-bit target, an 8-bit attribute and a size field. Every window covers a power-of-two span of at least 64 KiB.

The decode path takes one physical address per cycle and returns the result one cycle later. The result is a hit flag, the target and attribute of the lowest-numbered enabled window that covers the address, and the address to forward. A remappable window swaps the upper address bits for its remap value and keeps the offset. Other windows pass the address through unchanged. Windows that translate and windows that do not sit side by side in the same bank.

Top module: `awin_decoder`

## Requirements
- R1: After reset every window word reads as zero and every decode is a miss.
- R2: Control word fields: bit 0 enable, bit 1 sync-barrier flag, bits 7:4 target, bits 15:8 attribute, bits 31:16 size field. On a hit, the outputs carry the target and attribute of the winning window.
- R3: Window size is {size field, 16'hFFFF} + 1. The base word puts address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. An address hits when all of its 36 bits above the size mask equal the base, so the upper nibble is compared too.
- R4: A window whose enable bit is clear never hits, whatever its base and size.
- R5: For a window with index below REMAP_WINS, a hit outputs the remap address plus the offset of the input address within the window. Remap-low bits 31:16 give address bits 31:16, and remap-high bits 3:0 give address bits 35:32.
- R6: A hit in a window with index at or above REMAP_WINS outputs the input address unchanged.
- R7: When several enabled windows cover an address, the lowest-numbered one wins.
- R8: A miss drives hit low, target and attribute to zero, and passes the input address through unchanged.
- R9: For windows at or above REMAP_WINS, the remap selectors (reg_sel 2 and 3) read as zero and writes to them are ignored.
- R10: A clear strobe zeroes the control, base and remap words of the addressed window in one cycle, which disables it.
- R11: Decode results appear one cycle after the address, with out_valid following dec_valid. A register write is used by decodes from the next cycle on, so a decode presented in the write cycle still sees the old settings.
- R12: Readback keeps only the defined bits. Control keeps all 32 bits, base keeps bits 31:16 and 3:0, remap-low keeps bits 31:16, and remap-high keeps bits 3:0. reg_sel selects 0 control, 1 base, 2 remap-low, 3 remap-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_clr | input | 1 | Clear all words of the addressed window |
| reg_win | input | WIN_IDX_W | Window index for register access |
| reg_sel | input | 2 | Word select: 0 control, 1 base, 2 remap-low, 3 remap-high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| dec_valid | input | 1 | Decode request valid |
| dec_addr | input | 36 | Physical address to decode |
| out_valid | output | 1 | Decode result valid |
| out_hit | output | 1 | Address is covered by an enabled window |
| out_target | output | 4 | Target of the winning window |
| out_attr | output | 8 | Attribute of the winning window |
| out_addr | output | 36 | Translated or passed-through address |

## Verification
Directed cases first place addresses just inside and just outside a window's last byte. These separate a correct size mask from an off-by-one span. Other directed cases vary only the upper nibble, which shows that all 36 bits are compared. Overlapping windows reveal whether priority goes to the lowest index, and a disabled window with a matching base shows whether the enable bit gates the match. Random rounds program windows of mixed sizes, both remappable and not, then draw addresses near those windows. The bench predicts each result with range arithmetic (base ≤ address < base + size, output = remap + offset) rather than the RTL's masks, so a mask or translation slip shows up as a mismatch.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam int PA_W = 36;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } awd_sel_e;

  typedef struct packed {
    logic [15:0] size_m1;
    logic [7:0]  attr;
    logic [3:0]  target;
    logic [1:0]  rsvd;
    logic        sync_bar;
    logic        enable;
  } awd_ctrl_t;

  // bits of the address that lie inside the window (ones = offset)
  function automatic logic [PA_W-1:0] offset_mask(input logic [31:0] ctrl);
    return {4'h0, ctrl[31:16], 16'hFFFF};
  endfunction

  function automatic logic [PA_W-1:0] base_addr(input logic [31:0] base);
    return {base[3:0], base[31:16], 16'h0000};
  endfunction

  function automatic logic [PA_W-1:0] remap_addr(input logic [31:0] rlo,
                                                 input logic [31:0] rhi);
    return {rhi[3:0], rlo[31:16], 16'h0000};
  endfunction

  function automatic logic win_covers(input logic [PA_W-1:0] addr,
                                      input logic [31:0] ctrl,
                                      input logic [31:0] base);
    logic [PA_W-1:0] m;
    m = offset_mask(ctrl);
    return ctrl[0] && ((addr & ~m) == (base_addr(base) & ~m));
  endfunction

  function automatic logic [PA_W-1:0] translate(input logic [PA_W-1:0] addr,
                                                input logic [31:0] ctrl,
                                                input logic [31:0] rlo,
                                                input logic [31:0] rhi);
    logic [PA_W-1:0] m;
    m = offset_mask(ctrl);
    return (remap_addr(rlo, rhi) & ~m) | (addr & m);
  endfunction

  // storage masks for readback
  localparam logic [31:0] BASE_KEEP = 32'hFFFF_000F;
  localparam logic [31:0] RLO_KEEP  = 32'hFFFF_0000;
  localparam logic [31:0] RHI_KEEP  = 32'h0000_000F;

endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        clr,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q,
  output logic [31:0] base_q,
  output logic [31:0] rlo_q,
  output logic [31:0] rhi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else if (clr) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else if (we) begin
      if (sel == SEL_CTRL) ctrl_q <= wdata;
      if (sel == SEL_BASE) base_q <= wdata & BASE_KEEP;
    end
  end

  generate
    if (HAS_REMAP) begin : g_remap
      logic [31:0] rlo_r, rhi_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rlo_r <= '0;
          rhi_r <= '0;
        end else if (clr) begin
          rlo_r <= '0;
          rhi_r <= '0;
        end else if (we) begin
          if (sel == SEL_RLO) rlo_r <= wdata & RLO_KEEP;
          if (sel == SEL_RHI) rhi_r <= wdata & RHI_KEEP;
        end
      end
      assign rlo_q = rlo_r;
      assign rhi_q = rhi_r;
    end else begin : g_noremap
      assign rlo_q = '0;
      assign rhi_q = '0;
    end
  endgenerate

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic [PA_W-1:0] addr,
  input  logic [31:0]     ctrl,
  input  logic [31:0]     base,
  input  logic [31:0]     rlo,
  input  logic [31:0]     rhi,
  output logic            hit,
  output logic [PA_W-1:0] xlat
);

  assign hit = win_covers(addr, ctrl, base);

  generate
    if (HAS_REMAP) begin : g_xlat
      assign xlat = translate(addr, ctrl, rlo, rhi);
    end else begin : g_pass
      assign xlat = addr;
    end
  endgenerate

endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant  = '0;
        grant[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/awin_decoder.sv
module awin_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WINS   = 8,
  parameter int REMAP_WINS = 4,
  localparam int WIN_IDX_W = (NUM_WINS > 1) ? $clog2(NUM_WINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic                 reg_clr,
  input  logic [WIN_IDX_W-1:0] reg_win,
  input  logic [1:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 dec_valid,
  input  logic [35:0]          dec_addr,
  output logic                 out_valid,
  output logic                 out_hit,
  output logic [3:0]           out_target,
  output logic [7:0]           out_attr,
  output logic [35:0]          out_addr
);

  logic [31:0]     ctrl_w [NUM_WINS];
  logic [31:0]     base_w [NUM_WINS];
  logic [31:0]     rlo_w  [NUM_WINS];
  logic [31:0]     rhi_w  [NUM_WINS];
  logic [PA_W-1:0] xlat_w [NUM_WINS];

  // named internal events for the checker
  logic [NUM_WINS-1:0]  win_en_vec;
  logic [NUM_WINS-1:0]  win_hit_vec;
  logic [NUM_WINS-1:0]  win_grant;
  logic [WIN_IDX_W-1:0] win_sel_idx;
  logic                 any_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WINS; gi++) begin : g_win
      localparam bit REMAP_OK = (gi < REMAP_WINS);
      logic sel_me;
      assign sel_me = (reg_win == WIN_IDX_W'(gi));

      awd_win_regs #(.HAS_REMAP(REMAP_OK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we && sel_me),
        .clr    (reg_clr && sel_me),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_w[gi]),
        .base_q (base_w[gi]),
        .rlo_q  (rlo_w[gi]),
        .rhi_q  (rhi_w[gi])
      );

      awd_win_match #(.HAS_REMAP(REMAP_OK)) u_match (
        .addr (dec_addr),
        .ctrl (ctrl_w[gi]),
        .base (base_w[gi]),
        .rlo  (rlo_w[gi]),
        .rhi  (rhi_w[gi]),
        .hit  (win_hit_vec[gi]),
        .xlat (xlat_w[gi])
      );

      assign win_en_vec[gi] = ctrl_w[gi][0];
    end
  endgenerate

  awd_prio_sel #(.N(NUM_WINS)) u_prio (
    .req   (win_hit_vec),
    .grant (win_grant),
    .idx   (win_sel_idx),
    .any   (any_hit)
  );

  // register readback
  always_comb begin
    reg_rdata = '0;
    if (int'(reg_win) < NUM_WINS) begin
      unique case (reg_sel)
        SEL_CTRL: reg_rdata = ctrl_w[reg_win];
        SEL_BASE: reg_rdata = base_w[reg_win];
        SEL_RLO:  reg_rdata = rlo_w[reg_win];
        default:  reg_rdata = rhi_w[reg_win];
      endcase
    end
  end

  // decode result selection
  awd_ctrl_t   win_ctrl;
  logic [35:0] nxt_addr;
  always_comb begin
    win_ctrl = awd_ctrl_t'(ctrl_w[win_sel_idx]);
    nxt_addr = any_hit ? xlat_w[win_sel_idx] : dec_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_target <= '0;
      out_attr   <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= dec_valid;
      out_hit    <= dec_valid && any_hit;
      out_target <= (dec_valid && any_hit) ? win_ctrl.target : 4'h0;
      out_attr   <= (dec_valid && any_hit) ? win_ctrl.attr : 8'h00;
      out_addr   <= nxt_addr;
    end
  end

endmodule

// File: rtl/awin_decoder_chk.sv
module awin_decoder_chk #(
  parameter int NUM_WINS   = 8,
  parameter int REMAP_WINS = 4,
  localparam int WIN_IDX_W = (NUM_WINS > 1) ? $clog2(NUM_WINS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WIN_IDX_W-1:0] reg_win,
  input logic [1:0]           reg_sel,
  input logic [31:0]          reg_rdata,
  input logic                 dec_valid,
  input logic [35:0]          dec_addr,
  input logic                 out_valid,
  input logic                 out_hit,
  input logic [3:0]           out_target,
  input logic [7:0]           out_attr,
  input logic [35:0]          out_addr,
  input logic [NUM_WINS-1:0]  win_en_vec,
  input logic [NUM_WINS-1:0]  win_hit_vec,
  input logic [NUM_WINS-1:0]  win_grant
);

  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_target == 4'h0 && out_attr == 8'h00
                                 && out_addr == $past(dec_addr)));

  p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> out_addr[15:0] == $past(dec_addr[15:0]));

  p_disabled_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit_vec & ~win_en_vec) == '0);

  p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_grant) && ((win_grant - 1'b1) & win_hit_vec) == '0);

  p_noremap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel[1] && int'(reg_win) >= REMAP_WINS) |-> reg_rdata == 32'h0);

endmodule

bind awin_decoder awin_decoder_chk #(.NUM_WINS(NUM_WINS), .REMAP_WINS(REMAP_WINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_win     (reg_win),
  .reg_sel     (reg_sel),
  .reg_rdata   (reg_rdata),
  .dec_valid   (dec_valid),
  .dec_addr    (dec_addr),
  .out_valid   (out_valid),
  .out_hit     (out_hit),
  .out_target  (out_target),
  .out_attr    (out_attr),
  .out_addr    (out_addr),
  .win_en_vec  (win_en_vec),
  .win_hit_vec (win_hit_vec),
  .win_grant   (win_grant)
);

// File: tb/awin_decoder_tb.sv
module awin_decoder_tb;

  localparam int NW = 8;
  localparam int RW = 4;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_clr = 1'b0;
  logic [IW-1:0] reg_win = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dec_valid = 1'b0;
  logic [35:0] dec_addr = '0;
  logic        out_valid, out_hit;
  logic [3:0]  out_target;
  logic [7:0]  out_attr;
  logic [35:0] out_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  awin_decoder #(.NUM_WINS(NW), .REMAP_WINS(RW)) u_dut (.*);

  // bench model of the stored words
  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NW];
  logic [31:0] m_rhi  [NW];

  function automatic logic [31:0] model_read(int w, int s);
    case (s)
      0: return m_ctrl[w];
      1: return m_base[w];
      2: return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  // range-based prediction
  function automatic void predict(input logic [35:0] a, output logic h,
                                  output logic [3:0] t, output logic [7:0] at,
                                  output logic [35:0] oa);
    h = 0; t = 0; at = 0; oa = a;
    for (int i = 0; i < NW; i++) begin
      logic [36:0] lo, sz;
      if (!h && m_ctrl[i][0]) begin
        lo = {1'b0, m_base[i][3:0], m_base[i][31:16], 16'h0};
        sz = {5'h0, m_ctrl[i][31:16], 16'hFFFF} + 37'd1;
        if ({1'b0, a} >= lo && {1'b0, a} < lo + sz) begin
          h = 1; t = m_ctrl[i][7:4]; at = m_ctrl[i][15:8];
          if (i < RW)
            oa = 36'({m_rhi[i][3:0], m_rlo[i][31:16], 16'h0} + ({1'b0, a} - lo));
        end
      end
    end
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(int w, int s, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_win = IW'(w); reg_sel = 2'(s); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (w < NW) begin
      case (s)
        0: m_ctrl[w] = d;
        1: m_base[w] = d & 32'hFFFF_000F;
        2: if (w < RW) m_rlo[w] = d & 32'hFFFF_0000;
        default: if (w < RW) m_rhi[w] = d & 32'h0000_000F;
      endcase
    end
  endtask

  task automatic clr(int w);
    @(negedge clk);
    reg_clr = 1; reg_win = IW'(w);
    @(negedge clk);
    reg_clr = 0;
    m_ctrl[w] = 0; m_base[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
  endtask

  task automatic rd_check(string req, int w, int s);
    reg_win = IW'(w); reg_sel = 2'(s);
    #1;
    check(req, $sformatf("read w%0d s%0d", w, s), 64'(reg_rdata), 64'(model_read(w, s)));
  endtask

  task automatic dec(string req, logic [35:0] a);
    logic h; logic [3:0] t; logic [7:0] at; logic [35:0] oa;
    predict(a, h, t, at, oa);
    @(negedge clk);
    dec_valid = 1; dec_addr = a;
    @(negedge clk);
    dec_valid = 0;
    check(req, "valid", 64'(out_valid), 64'd1);
    check(req, $sformatf("hit @%h", a), 64'(out_hit), 64'(h));
    check(req, "target", 64'(out_target), 64'(t));
    check(req, "attr", 64'(out_attr), 64'(at));
    check(req, "addr", 64'(out_addr), 64'(oa));
  endtask

  function automatic logic [31:0] mk_ctrl(int k, logic [3:0] t, logic [7:0] at, bit en);
    logic [15:0] s;
    s = 16'((32'd1 << k) - 1);
    return {s, at, t, 3'b000, en};
  endfunction

  function automatic logic [31:0] mk_base(logic [35:0] a);
    return {a[31:16], 12'h0, a[35:32]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int junk;
    junk = $urandom(32'd1234);
    for (int i = 0; i < NW; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++) rd_check("R1", w, s);
    dec("R1", 36'h0_0000_1234);

    // R2 R5: window 0 remapped, 1 MiB
    wr(0, 1, mk_base(36'h3_1230_0000) | 32'h0000_FFF0);
    wr(0, 2, 32'hABC0_FFFF);
    wr(0, 3, 32'hFFFF_FFF5);
    wr(0, 0, mk_ctrl(4, 4'hA, 8'h5C, 1) | 32'h2);
    // R12 readback masks
    for (int s = 0; s < 4; s++) rd_check("R12", 0, s);
    dec("R5", 36'h3_1230_0000);
    dec("R5", 36'h3_123F_FFFF);   // last byte
    dec("R3", 36'h3_1240_0000);   // one past end
    dec("R3", 36'h2_1230_0010);   // upper nibble differs
    dec("R2", 36'h3_1235_4321);

    // R6 non-remappable window 5
    wr(5, 1, mk_base(36'h0_8000_0000));
    wr(5, 0, mk_ctrl(0, 4'h3, 8'hE1, 1));
    dec("R6", 36'h0_8000_ABCD);
    dec("R8", 36'h0_8001_0000);

    // R9 remap regs of window 5
    wr(5, 2, 32'hFFFF_FFFF);
    wr(5, 3, 32'hFFFF_FFFF);
    rd_check("R9", 5, 2);
    rd_check("R9", 5, 3);
    dec("R9", 36'h0_8000_0042);

    // R7 overlap: window 2 covers the same span as 5, lower index wins
    wr(2, 1, mk_base(36'h0_8000_0000));
    wr(2, 2, mk_base(36'h0_4400_0000));
    wr(2, 0, mk_ctrl(8, 4'h7, 8'h11, 1));
    dec("R7", 36'h0_8000_0100);

    // R4 disabled window with matching base
    wr(2, 0, mk_ctrl(8, 4'h7, 8'h11, 0));
    dec("R4", 36'h0_8002_0000);
    dec("R4", 36'h0_8000_0100);

    // R11 decode in the write cycle sees old settings
    begin
      logic h; logic [3:0] t; logic [7:0] at; logic [35:0] oa;
      predict(36'h0_8000_0100, h, t, at, oa);
      @(negedge clk);
      reg_we = 1; reg_win = 3'd5; reg_sel = 2'd0; reg_wdata = mk_ctrl(0, 4'h3, 8'hE1, 0);
      dec_valid = 1; dec_addr = 36'h0_8000_0100;
      @(negedge clk);
      reg_we = 0; dec_valid = 0;
      m_ctrl[5] = mk_ctrl(0, 4'h3, 8'hE1, 0);
      check("R11", "old cfg hit", 64'(out_hit), 64'(h));
      check("R11", "old cfg target", 64'(out_target), 64'(t));
      @(negedge clk);
      check("R11", "valid drops", 64'(out_valid), 64'd0);
      dec("R11", 36'h0_8000_0100);
    end

    // R10 clear
    clr(0);
    for (int s = 0; s < 4; s++) rd_check("R10", 0, s);
    dec("R10", 36'h3_1230_0000);

    // random rounds
    for (int r = 0; r < 300; r++) begin
      int w, k;
      logic [35:0] b, rm, a;
      w = int'($urandom_range(0, NW - 1));
      k = int'($urandom_range(0, 6));
      b = {4'($urandom), 16'($urandom), 16'h0};
      b[31:16] = b[31:16] & ~16'((32'd1 << k) - 1);
      rm = {4'($urandom), 16'($urandom), 16'h0};
      rm[31:16] = rm[31:16] & ~16'((32'd1 << k) - 1);
      if ($urandom_range(0, 5) == 0) clr(w);
      else begin
        wr(w, 1, mk_base(b));
        wr(w, 2, rm[31:0]);
        wr(w, 3, {28'($urandom), rm[35:32]});
        wr(w, 0, mk_ctrl(k, 4'($urandom), 8'($urandom), ($urandom_range(0, 4) != 0)));
      end
      rd_check("R12", w, int'($urandom_range(0, 3)));
      a = b + 36'({$urandom} % (32'h20000 << k));
      if ($urandom_range(0, 3) == 0) a = {4'($urandom), 32'($urandom)};
      dec(m_ctrl[w][0] ? "R3" : "R4", a);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule